// File: doc/BRIEF.md
# Field-Interleaving Frame Store Writer

This block sits in the memory clock domain, behind a FIFO that carries video from the capture domain. Each FIFO word holds one pixel byte plus three framing flags: field start, line start and field parity. The writer pops one word at a time. It works out where that pixel belongs in a progressive frame buffer and hands the word to a memory-controller port as a single write request. It then waits for the controller to acknowledge the write before it takes the next word.

Interlaced video sends all even rows of a picture as one field and all odd rows as the next. The writer places each line of a field at row `2*line + parity`. The two fields therefore fill alternating rows, and after both fields have arrived the buffer holds one whole picture in scan order. When the last pixel of the last line of the parity-1 field has been written, the block raises a completion strobe for one cycle.

Top module: `fstore_wr`

## Requirements
- R1: While reset is held, and until a word has been popped after reset, `mem_wr` and `frame_done` are 0. With an empty FIFO, `fifo_rd` is also 0.
- R2: `fifo_rd` is high only in a cycle where `fifo_empty` is 0 and no write is outstanding. It is never high in the same cycle as `mem_wr`, and each pop leads to exactly one write.
- R3: `mem_wr` rises in the cycle after a pop. It stays high, with `mem_addr` and `mem_wdata` held constant, up to and including the cycle in which `mem_done` is high. It is low in the next cycle. With a controller delay of L cycles, `mem_wr` is high for L+1 cycles per word.
- R4: A FIFO word is laid out as bit DATA_W+2 = field start, bit DATA_W+1 = line start, bit DATA_W = field parity, and bits DATA_W-1:0 = pixel. The pixel bits appear unchanged on `mem_wdata`.
- R5: A word with the field-start bit set takes line 0, column 0. This bit wins over the line-start bit when both are set.
- R6: A word with only the line-start bit set takes column 0, and the line count goes up by one.
- R7: A word with neither bit set takes the next column on the same line.
- R8: The write address is `(2*line + parity) * WORDS_PER_LINE + column`.
- R9: The column count stops at WORDS_PER_LINE-1 and the line count stops at LINES_PER_FIELD-1. Surplus words rewrite the last position and never spill into another row. Every address stays below the frame size.
- R10: `frame_done` is high for exactly one cycle: the cycle after `mem_done` acknowledges a word with parity 1, line LINES_PER_FIELD-1 and column WORDS_PER_LINE-1. It is never high at any other time.
- R11: `mem_done` is ignored while no write is outstanding. Such a pulse writes nothing, raises no strobe, and leaves the line and column counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_rdata | input | DATA_W+3 | Head word of the FIFO (show-ahead): flags and pixel |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_rd | output | 1 | Pop the head word |
| mem_addr | output | $clog2(2*WORDS_PER_LINE*LINES_PER_FIELD) | Frame-buffer word address |
| mem_wdata | output | DATA_W | Pixel to store |
| mem_wr | output | 1 | Write request, held until acknowledged |
| mem_done | input | 1 | Controller acknowledge for the current write |
| frame_done | output | 1 | One-cycle strobe after the final word of a frame |

## Verification
Each result has a fixed cycle. A pop falls in the same cycle the FIFO shows a word while the writer is idle. The address, data and request appear one register later. The request is held through the acknowledge cycle, and the completion strobe comes one cycle after that acknowledge. The controller model raises `mem_done` 2 ns after a rising edge, after a chosen delay, and the FIFO model advances just after the edge on which a pop was seen. All outputs are sampled on the falling edge, so every result is read in the middle of the cycle it belongs to. Tying each logged write to its pop order lets address, data and strobe be checked per word, and the delay is varied to show the request length follows the controller.

// File: rtl/fstore_pkg.sv
`timescale 1ns/1ps
package fstore_pkg;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } fs_state_e;

  typedef struct packed {
    logic fstart;
    logic lstart;
    logic parity;
  } fs_tag_t;

endpackage

// File: rtl/fstore_pos.sv
`timescale 1ns/1ps
module fstore_pos
  import fstore_pkg::*;
#(
  parameter int WPL = 1440,
  parameter int LPF = 243,
  parameter int AW  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  fs_tag_t       tag,
  output logic [AW-1:0] addr_n,
  output logic          last_n
);

  localparam int CW = (WPL > 1) ? $clog2(WPL) : 1;
  localparam int LW = (LPF > 1) ? $clog2(LPF) : 1;
  localparam logic [CW-1:0] COL_END  = CW'(WPL - 1);
  localparam logic [LW-1:0] LINE_END = LW'(LPF - 1);

  logic [CW-1:0] col_q, col_n;
  logic [LW-1:0] line_q, line_n;

  always_comb begin
    col_n  = col_q;
    line_n = line_q;
    if (tag.fstart) begin
      col_n  = '0;
      line_n = '0;
    end else if (tag.lstart) begin
      col_n = '0;
      if (line_q != LINE_END) line_n = line_q + 1'b1;
    end else if (col_q != COL_END) begin
      col_n = col_q + 1'b1;
    end
  end

  always_comb begin
    addr_n = AW'({line_n, tag.parity}) * AW'(WPL) + AW'(col_n);
    last_n = tag.parity && (line_n == LINE_END) && (col_n == COL_END);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      line_q <= '0;
    end else if (adv) begin
      col_q  <= col_n;
      line_q <= line_n;
    end
  end

endmodule

// File: rtl/fstore_seq.sv
`timescale 1ns/1ps
module fstore_seq
  import fstore_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_empty,
  input  logic mem_done,
  output logic pop,
  output logic busy,
  output logic wr_end
);

  fs_state_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE:  if (!fifo_empty) st_n = ST_WRITE;
      ST_WRITE: if (mem_done)    st_n = ST_IDLE;
      default:                   st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  assign pop    = (st_q == ST_IDLE) && !fifo_empty;
  assign busy   = (st_q == ST_WRITE);
  assign wr_end = busy && mem_done;

endmodule

// File: rtl/fstore_wr.sv
`timescale 1ns/1ps
module fstore_wr
  import fstore_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int WORDS_PER_LINE  = 1440,
  parameter int LINES_PER_FIELD = 243,
  localparam int FRAME_W = 2 * WORDS_PER_LINE * LINES_PER_FIELD,
  localparam int ADDR_W  = $clog2(FRAME_W),
  localparam int TAG_W   = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  fifo_rdata,
  input  logic              fifo_empty,
  output logic              fifo_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wr,
  input  logic              mem_done,
  output logic              frame_done
);

  logic [1:0] sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_q = sync_q[1];

  fs_tag_t            tag;
  logic [ADDR_W-1:0]  addr_n, addr_q;
  logic [DATA_W-1:0]  data_q;
  logic               last_n, last_q, done_q;
  logic               pop, busy, wr_end;

  assign tag = fs_tag_t'(fifo_rdata[TAG_W-1:DATA_W]);

  fstore_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_q),
    .fifo_empty (fifo_empty),
    .mem_done   (mem_done),
    .pop        (pop),
    .busy       (busy),
    .wr_end     (wr_end)
  );

  fstore_pos #(
    .WPL (WORDS_PER_LINE),
    .LPF (LINES_PER_FIELD),
    .AW  (ADDR_W)
  ) u_pos (
    .clk    (clk),
    .rst_n  (rst_q),
    .adv    (pop),
    .tag    (tag),
    .addr_n (addr_n),
    .last_n (last_n)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      addr_q <= '0;
      data_q <= '0;
      last_q <= 1'b0;
    end else if (pop) begin
      addr_q <= addr_n;
      data_q <= fifo_rdata[DATA_W-1:0];
      last_q <= last_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) done_q <= 1'b0;
    else        done_q <= wr_end && last_q;
  end

  assign fifo_rd    = pop;
  assign mem_addr   = addr_q;
  assign mem_wdata  = data_q;
  assign mem_wr     = busy;
  assign frame_done = done_q;

endmodule

// File: rtl/fstore_wr_chk.sv
`timescale 1ns/1ps
module fstore_wr_chk #(
  parameter int AW      = 5,
  parameter int DW      = 8,
  parameter int FRAME_W = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_empty,
  input logic          fifo_rd,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_wr,
  input logic          mem_done,
  input logic          frame_done
);

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) fifo_rd |-> !fifo_empty); // R2
  AST_NO_POP_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> !fifo_rd); // R2
  AST_POP_THEN_WR:  assert property (@(posedge clk) disable iff (!rst_n) fifo_rd |=> mem_wr); // R3
  AST_WR_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) (mem_wr && !mem_done) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R3
  AST_WR_RELEASE:   assert property (@(posedge clk) disable iff (!rst_n) (mem_wr && mem_done) |=> !mem_wr); // R3
  AST_ADDR_RANGE:   assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> ({1'b0, mem_addr} < (AW+1)'(FRAME_W))); // R9
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> !frame_done); // R10
  AST_DONE_AFTER:   assert property (@(posedge clk) disable iff (!rst_n) frame_done |-> $past(mem_wr && mem_done)); // R10

endmodule

bind fstore_wr fstore_wr_chk #(
  .AW      (ADDR_W),
  .DW      (DATA_W),
  .FRAME_W (FRAME_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_empty (fifo_empty),
  .fifo_rd    (fifo_rd),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_wr     (mem_wr),
  .mem_done   (mem_done),
  .frame_done (frame_done)
);

// File: tb/sim_fstore_wr.sv
`timescale 1ns/1ps
module sim_fstore_wr;

  localparam int DW = 8, WPL = 4, LPF = 3, AW = 5, TW = 11;

  localparam logic [TW-1:0] VW [15] = '{
    {3'b100, 8'h10}, {3'b000, 8'h11}, {3'b000, 8'h12}, {3'b010, 8'h13},
    {3'b000, 8'h14}, {3'b101, 8'h15}, {3'b001, 8'h16}, {3'b011, 8'h17},
    {3'b011, 8'h18}, {3'b001, 8'h19}, {3'b001, 8'h1A}, {3'b001, 8'h1B},
    {3'b001, 8'h1C}, {3'b011, 8'h1D}, {3'b110, 8'h1E}
  };
  localparam int VA [15] = '{0, 1, 2, 8, 9, 4, 5, 12, 20, 21, 22, 23, 23, 20, 0};
  localparam bit VD [15] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [TW-1:0] fifo_rdata;
  logic          fifo_empty, fifo_rd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_wr, mem_done, frame_done;

  fstore_wr #(.DATA_W(DW), .WORDS_PER_LINE(WPL), .LINES_PER_FIELD(LPF)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
    .fifo_rd(fifo_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wr(mem_wr), .mem_done(mem_done), .frame_done(frame_done)
  );

  int checks = 0, errs = 0;
  bit ended = 0;

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // show-ahead FIFO model
  logic [TW-1:0] fq [128];
  int rd_i = 0, wr_i = 0;
  assign fifo_empty = (rd_i == wr_i);
  assign fifo_rdata = fq[rd_i[6:0]];

  initial forever begin
    bit p;
    @(negedge clk);
    p = fifo_rd;
    @(posedge clk);
    #1;
    if (p) rd_i++;
  end

  task automatic push(logic [TW-1:0] w);
    fq[wr_i[6:0]] = w;
    wr_i++;
  endtask

  // controller model
  int lat = 0, cnt = 0;
  bit force_done = 0;
  initial begin
    mem_done = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      if (mem_wr) cnt++; else cnt = 0;
      mem_done = force_done || (mem_wr && cnt > lat);
    end
  end

  // monitor
  logic [AW-1:0] log_a [128];
  logic [DW-1:0] log_d [128];
  bit            dflag [128];
  int wr_n = 0, done_n = 0, pop_n = 0, overlap_n = 0, wrcyc_n = 0, unstable_n = 0;
  logic prev_wr = 0, prev_done = 0;
  logic [AW-1:0] prev_a = '0;

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (fifo_rd) pop_n++;
      if (fifo_rd && mem_wr) overlap_n++;
      if (mem_wr) wrcyc_n++;
      if (mem_wr && prev_wr && !prev_done && mem_addr != prev_a) unstable_n++;
      if (frame_done) begin
        done_n++;
        if (wr_n > 0) dflag[wr_n-1] = 1'b1;
      end
      if (mem_wr && mem_done) begin
        log_a[wr_n] = mem_addr;
        log_d[wr_n] = mem_wdata;
        wr_n++;
      end
    end
    prev_wr = mem_wr; prev_done = mem_done; prev_a = mem_addr;
  end

  task automatic drain();
    @(negedge clk);
    while (!(fifo_empty && !mem_wr)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!ended) begin
      ended = 1;
      checks++; errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int base, w0, d0, p0, c0;
    for (int i = 0; i < 128; i++) dflag[i] = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mem_wr in reset", mem_wr, 0);
    chk("R1 frame_done in reset", frame_done, 0);
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 mem_wr idle", mem_wr, 0);
    chk("R1 frame_done idle", frame_done, 0);
    chk("R1 fifo_rd empty", fifo_rd, 0);

    // vector table, zero-delay controller
    lat = 0; base = wr_n; p0 = pop_n;
    @(posedge clk); #3;
    for (int i = 0; i < 15; i++) push(VW[i]);
    drain();
    chk("R2 one pop per word", pop_n - p0, 15);
    chk("R2 one write per pop", wr_n - base, 15);
    for (int i = 0; i < 15; i++) begin
      string rq;
      rq = (i == 12 || i == 13) ? "R9 clamp addr" : (i == 14) ? "R5 priority addr" : "R8 addr";
      chk(rq, int'(log_a[base+i]), VA[i]);
      chk("R4 data", int'(log_d[base+i]), int'(VW[i][7:0]));
      chk("R10 strobe", int'(dflag[base+i]), int'(VD[i]));
    end

    // controller delay: request length
    lat = 3; c0 = wrcyc_n;
    @(posedge clk); #3;
    push({3'b100, 8'hA0}); push({3'b000, 8'hA1});
    drain();
    chk("R3 request cycles", wrcyc_n - c0, 8);
    chk("R3 stable while waiting", unstable_n, 0);
    chk("R2 no pop during write", overlap_n, 0);

    // whole frame, both fields
    lat = 1; base = wr_n; d0 = done_n;
    @(posedge clk); #3;
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < LPF; l++)
        for (int c = 0; c < WPL; c++)
          push({(l == 0 && c == 0), (c == 0 && l != 0), f[0], 8'(f*64 + l*16 + c)});
    drain();
    for (int k = 0; k < 24; k++) begin
      int f, l, c;
      string rq;
      f = k / 12; l = (k % 12) / WPL; c = k % WPL;
      rq = (c != 0) ? "R7 addr" : (l == 0) ? "R5 addr" : "R6 addr";
      chk(rq, int'(log_a[base+k]), (2*l + f) * WPL + c);
    end
    chk("R10 single strobe per frame", done_n - d0, 1);
    chk("R10 strobe after last word", int'(dflag[base+23]), 1);

    // stray acknowledge while idle
    w0 = wr_n; d0 = done_n;
    @(posedge clk); #3 force_done = 1;
    repeat (3) @(negedge clk);
    chk("R11 no request", mem_wr, 0);
    @(posedge clk); #3 force_done = 0;
    repeat (3) @(negedge clk);
    chk("R11 no write", wr_n - w0, 0);
    chk("R11 no strobe", done_n - d0, 0);
    lat = 0; base = wr_n;
    @(posedge clk); #3 push({3'b000, 8'h55});
    drain();
    chk("R11 counts kept (R9 clamp)", int'(log_a[base]), 19);

    // reset during an outstanding write
    lat = 6;
    @(posedge clk); #3 push({3'b000, 8'h66});
    @(negedge clk); @(negedge clk);
    chk("R3 request pending", mem_wr, 1);
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R1 request dropped by reset", mem_wr, 0);
    chk("R1 strobe low in reset", frame_done, 0);
    repeat (2) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    lat = 0; base = wr_n;
    @(posedge clk); #3 push({3'b100, 8'h77});
    drain();
    chk("R5 addr after reset", int'(log_a[base]), 0);
    chk("R4 data after reset", int'(log_d[base]), 8'h77);

    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule